// File: doc/BRIEF.md
# Subscriber line state controller

This block is a synchronous controller placed between a host and an analog line interface circuit. It drives a power enable line and three mode lines toward that circuit, and it watches the circuit's active-low loop detector. The host asks for a line condition with a two-bit command: power down, idle high-impedance feed, active feed, or ringing. The controller turns that request into the mode-line encoding. It also produces the ringing itself. During a ring burst it toggles the polarity line at a programmed half-period. Bursts alternate with pauses of programmed length.

The loop detector passes through a two-flop synchronizer and a programmable debounce before any decision is made. In idle and active feed, an asserted detector means off-hook. During a burst or a pause, it means ring trip. On ring trip the controller stops toggling by itself and places the line in active feed with normal polarity. It keeps normal polarity until the host withdraws the ring command. A metering request in active feed opens the metering clock enable for a guard interval. The metering mode line is then held for the programmed pulse length, and a second guard interval follows before the enable closes again.

A supply-good input holds every control output low until it asserts. A thermal or emergency input forces power down, and the previous line condition comes back once that input clears. All durations are counts of a tick enable input.

States: ST_HOLD (supply not good), ST_PDN (power down), ST_THERM (forced power down), ST_IDLE (high-impedance feed), ST_ACT (active feed), ST_RING_ON (ring burst), ST_RING_PAUSE (ring pause), ST_MTR_PRE, ST_MTR_ON and ST_MTR_POST (metering guard, pulse and guard). Transitions:
- Supply loss leads from any state to ST_HOLD. ST_HOLD leads to ST_PDN once supply is good.
- A thermal alarm leads from any state to ST_THERM. Clearing the alarm leads back to the saved state. A metering state is saved as ST_ACT, and a pause is saved as ST_RING_ON.
- The host command moves the line between ST_PDN, ST_IDLE, ST_ACT and ST_RING_ON.
- Within ringing, the end of a burst leads to the pause, and the end of a pause leads to the next burst.
- Ring trip leads from a burst or a pause to ST_ACT.
- A metering request leads from ST_ACT to ST_MTR_PRE, then ST_MTR_ON, then ST_MTR_POST, and back to ST_ACT.

Top module: `sline_ctrl`

## Requirements
- R1: While pwr_good is low, and from reset, ln_on, ln_m0, ln_m1, ln_pol and mclk_en are all 0 whatever the other inputs are. The outputs are all 0 in the cycle after pwr_good is seen low.
- R2: host_cmd = 2'b00 gives power down: ln_on = 0 and ln_m0 = ln_m1 = ln_pol = 0. Whenever ln_on is 0, ln_m0 and ln_m1 are 0.
- R3: host_cmd = 2'b01 gives idle high-impedance feed: ln_on = 1, ln_m0 = 0, ln_m1 = 0, ln_pol = 0.
- R4: host_cmd = 2'b10 gives active feed: ln_on = 1, ln_m0 = 0, ln_m1 = 1, and ln_pol equals host_rev (1 means reversed polarity), following it one cycle later.
- R5: host_cmd = 2'b11 gives a ring burst: ln_on = 1, ln_m0 = 1, ln_m1 = 0. ln_pol starts at 0 and inverts after every cfg_half ticks.
- R6: A burst lasts cfg_burst ticks. A pause of cfg_pause ticks follows, with active normal outputs (ln_m0 = 0, ln_m1 = 1, ln_pol = 0). A new burst, starting again with ln_pol = 0, follows each pause.
- R7: A debounced detector assertion during a burst or a pause sends the line to active feed with ln_pol = 0 in the next cycle and sets offhook. ln_pol stays 0, whatever host_rev is, until host_cmd leaves 2'b11.
- R8: In idle or active feed, offhook sets when the debounced detector asserts. It clears only after the detector has been deasserted for cfg_onhook + 1 consecutive ticks. It is cleared in power down.
- R9: The detector goes through two synchronizing flops. A change is accepted only after it has persisted for cfg_deb ticks, so a shorter glitch changes nothing.
- R10: meter_req in active feed with host_cmd = 2'b10 raises mclk_en for cfg_guard ticks with ln_m0 = 0. ln_m0 and ln_m1 are then both 1 for cfg_meter ticks. mclk_en stays 1 for a further cfg_guard ticks, then the line returns to active feed. ln_pol is held throughout, and ln_m0 is never 1 with ln_m1 = 1 unless mclk_en is 1.
- R11: therm_alarm forces power down (ln_on = 0) from the next cycle. When it clears, the previous line condition is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing enable; all durations count its cycles |
| pwr_good | input | 1 | Supply-good indication |
| therm_alarm | input | 1 | Thermal or emergency power-down request |
| host_cmd | input | 2 | Requested line condition: 00 down, 01 idle, 10 active, 11 ring |
| host_rev | input | 1 | Requested polarity in active feed (1 = reversed) |
| meter_req | input | 1 | Starts one metering pulse in active feed |
| det_n | input | 1 | Loop detector from the line circuit, active low, asynchronous |
| cfg_deb | input | CNT_W | Debounce length in ticks |
| cfg_onhook | input | CNT_W | On-hook reference time in ticks |
| cfg_half | input | CNT_W | Ring half-period in ticks |
| cfg_burst | input | CNT_W | Ring burst length in ticks |
| cfg_pause | input | CNT_W | Ring pause length in ticks |
| cfg_meter | input | CNT_W | Metering pulse length in ticks |
| cfg_guard | input | CNT_W | Metering rise/decay guard in ticks |
| ln_on | output | 1 | Line circuit powered (0 opens the line when both mode lines are 0) |
| ln_m0 | output | 1 | Mode line 0 |
| ln_m1 | output | 1 | Mode line 1 |
| ln_pol | output | 1 | Polarity line (0 normal, 1 reversed); toggles during a burst |
| mclk_en | output | 1 | Metering clock enable |
| offhook | output | 1 | Debounced loop status |

## Verification
The bench keeps the default CNT_W of 16 and holds tick high. It programs short durations: debounce 3, on-hook reference 20, half-period 5, burst 23, pause 12, metering pulse 9 and guard 4. With these values, a whole burst-and-pause cycle fits in a few dozen cycles. Exact lengths of bursts, half-periods, pauses and guard intervals can therefore be counted at the outputs. A three-cycle detector glitch falls below the debounce length, and the on-hook release can be seen on both sides of its threshold. Random commands, polarities and thermal pulses between the directed cases exercise returns from every line condition.

// File: rtl/sline_pkg.sv
package sline_pkg;

    typedef enum logic [3:0] {
        ST_HOLD,
        ST_PDN,
        ST_THERM,
        ST_IDLE,
        ST_ACT,
        ST_RING_ON,
        ST_RING_PAUSE,
        ST_MTR_PRE,
        ST_MTR_ON,
        ST_MTR_POST
    } sl_state_t;

    localparam logic [1:0] CMD_PDN  = 2'b00;
    localparam logic [1:0] CMD_IDLE = 2'b01;
    localparam logic [1:0] CMD_ACT  = 2'b10;
    localparam logic [1:0] CMD_RING = 2'b11;

endpackage

// File: rtl/sline_detect.sv
// Two-flop synchronizer followed by a tick-based debounce of the
// active-low loop detector. det_q is 1 when the detector is asserted.
module sline_detect #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             det_n,
    input  logic [CNT_W-1:0] deb_len,
    output logic             det_q
);

    logic             sync1_n;
    logic             sync2_n;
    logic             stable_n;
    logic [CNT_W-1:0] deb_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_n <= 1'b1;
            sync2_n <= 1'b1;
        end else begin
            sync1_n <= det_n;
            sync2_n <= sync1_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_n <= 1'b1;
            deb_cnt  <= '0;
        end else if (sync2_n == stable_n) begin
            deb_cnt  <= '0;
        end else if (deb_cnt == deb_len) begin
            stable_n <= sync2_n;
            deb_cnt  <= '0;
        end else if (tick) begin
            deb_cnt  <= deb_cnt + 1'b1;
        end
    end

    assign det_q = ~stable_n;

endmodule

// File: rtl/sline_timer.sv
// Tick-counting interval timer. After a load of N it fires on the N-th
// following tick (a load of 0 or 1 fires on the first tick).
module sline_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt > LAST)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = tick && (cnt <= LAST);

endmodule

// File: rtl/sline_hook.sv
// Loop status tracker: sets on a detector assertion while sensing,
// releases after the detector stays clear for hold_len+1 ticks in feed.
module sline_hook #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             det_q,
    input  logic             sense,
    input  logic             feed,
    input  logic             clr,
    input  logic [CNT_W-1:0] hold_len,
    output logic             offhook
);

    logic [CNT_W-1:0] clear_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offhook   <= 1'b0;
            clear_cnt <= '0;
        end else if (clr) begin
            offhook   <= 1'b0;
            clear_cnt <= '0;
        end else if (sense && det_q) begin
            offhook   <= 1'b1;
            clear_cnt <= '0;
        end else if (feed && offhook && tick) begin
            if (clear_cnt == hold_len) begin
                offhook   <= 1'b0;
                clear_cnt <= '0;
            end else begin
                clear_cnt <= clear_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sline_ctrl.sv
module sline_ctrl
    import sline_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pwr_good,
    input  logic             therm_alarm,
    input  logic [1:0]       host_cmd,
    input  logic             host_rev,
    input  logic             meter_req,
    input  logic             det_n,
    input  logic [CNT_W-1:0] cfg_deb,
    input  logic [CNT_W-1:0] cfg_onhook,
    input  logic [CNT_W-1:0] cfg_half,
    input  logic [CNT_W-1:0] cfg_burst,
    input  logic [CNT_W-1:0] cfg_pause,
    input  logic [CNT_W-1:0] cfg_meter,
    input  logic [CNT_W-1:0] cfg_guard,
    output logic             ln_on,
    output logic             ln_m0,
    output logic             ln_m1,
    output logic             ln_pol,
    output logic             mclk_en,
    output logic             offhook
);

    sl_state_t        st;
    sl_state_t        st_nx;
    sl_state_t        resume_st;
    sl_state_t        goal_st;
    logic             det_q;
    logic             pol_q;
    logic             trip_hold;
    logic             trip_hold_nx;
    logic             trip_ev;
    logic             in_ring;
    logic             in_meter;
    logic             ph_load;
    logic [CNT_W-1:0] ph_val;
    logic             ph_done;
    logic             hf_load;
    logic             hf_done;
    logic             hook_sense;
    logic             hook_feed;
    logic             hook_clr;

    // ---------------- detector path ----------------
    sline_detect #(.CNT_W(CNT_W)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .det_n   (det_n),
        .deb_len (cfg_deb),
        .det_q   (det_q)
    );

    // ---------------- timers ----------------
    sline_timer #(.CNT_W(CNT_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (ph_load),
        .load_val (ph_val),
        .done     (ph_done)
    );

    sline_timer #(.CNT_W(CNT_W)) u_half_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (hf_load),
        .load_val (cfg_half),
        .done     (hf_done)
    );

    // ---------------- state classification ----------------
    assign in_ring  = (st == ST_RING_ON) || (st == ST_RING_PAUSE);
    assign in_meter = (st == ST_MTR_PRE) || (st == ST_MTR_ON) || (st == ST_MTR_POST);

    assign trip_ev      = pwr_good && !therm_alarm && det_q && in_ring;
    assign trip_hold_nx = trip_ev || (trip_hold && (host_cmd == CMD_RING));

    // target condition requested by the host
    always_comb begin
        unique case (host_cmd)
            CMD_PDN:  goal_st = ST_PDN;
            CMD_IDLE: goal_st = ST_IDLE;
            CMD_ACT:  goal_st = ST_ACT;
            default:  goal_st = trip_hold ? ST_ACT : ST_RING_ON;
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        st_nx = st;
        if (!pwr_good) begin
            st_nx = ST_HOLD;
        end else if (therm_alarm && (st != ST_HOLD) && (st != ST_THERM)) begin
            st_nx = ST_THERM;
        end else begin
            unique case (st)
                ST_HOLD:  st_nx = ST_PDN;
                ST_THERM: if (!therm_alarm) st_nx = resume_st;
                ST_PDN, ST_IDLE: st_nx = goal_st;
                ST_ACT: begin
                    if (meter_req && (host_cmd == CMD_ACT)) st_nx = ST_MTR_PRE;
                    else                                    st_nx = goal_st;
                end
                ST_RING_ON: begin
                    if (det_q)                       st_nx = ST_ACT;
                    else if (host_cmd != CMD_RING)   st_nx = goal_st;
                    else if (ph_done)                st_nx = ST_RING_PAUSE;
                end
                ST_RING_PAUSE: begin
                    if (det_q)                       st_nx = ST_ACT;
                    else if (host_cmd != CMD_RING)   st_nx = goal_st;
                    else if (ph_done)                st_nx = ST_RING_ON;
                end
                ST_MTR_PRE:  if (ph_done) st_nx = ST_MTR_ON;
                ST_MTR_ON:   if (ph_done) st_nx = ST_MTR_POST;
                ST_MTR_POST: if (ph_done) st_nx = ST_ACT;
                default:     st_nx = ST_HOLD;
            endcase
        end
    end

    // phase timer loads on entry to a timed state
    always_comb begin
        ph_load = 1'b0;
        ph_val  = '0;
        if (st_nx != st) begin
            unique case (st_nx)
                ST_RING_ON:    begin ph_load = 1'b1; ph_val = cfg_burst; end
                ST_RING_PAUSE: begin ph_load = 1'b1; ph_val = cfg_pause; end
                ST_MTR_PRE,
                ST_MTR_POST:   begin ph_load = 1'b1; ph_val = cfg_guard; end
                ST_MTR_ON:     begin ph_load = 1'b1; ph_val = cfg_meter; end
                default:       begin ph_load = 1'b0; ph_val = '0;        end
            endcase
        end
    end

    // half-period timer loads on burst entry and on every toggle
    assign hf_load = (st_nx == ST_RING_ON) && ((st != ST_RING_ON) || hf_done);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_HOLD;
            resume_st <= ST_PDN;
            trip_hold <= 1'b0;
        end else begin
            st        <= st_nx;
            trip_hold <= trip_hold_nx;
            if ((st_nx == ST_THERM) && (st != ST_THERM)) begin
                unique case (st)
                    ST_MTR_PRE, ST_MTR_ON, ST_MTR_POST: resume_st <= ST_ACT;
                    ST_RING_PAUSE:                      resume_st <= ST_RING_ON;
                    default:                            resume_st <= st;
                endcase
            end
        end
    end

    // polarity register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
        end else begin
            unique case (st_nx)
                ST_ACT:     pol_q <= host_rev && !trip_hold_nx;
                ST_MTR_PRE,
                ST_MTR_ON,
                ST_MTR_POST: pol_q <= pol_q;
                ST_RING_ON: begin
                    if (st != ST_RING_ON) pol_q <= 1'b0;
                    else if (hf_done)     pol_q <= ~pol_q;
                end
                default:    pol_q <= 1'b0;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ln_on   = 1'b0;
        ln_m0   = 1'b0;
        ln_m1   = 1'b0;
        ln_pol  = 1'b0;
        mclk_en = 1'b0;
        unique case (st)
            ST_HOLD, ST_PDN, ST_THERM: begin
                ln_on = 1'b0;
            end
            ST_IDLE: begin
                ln_on = 1'b1;
            end
            ST_ACT: begin
                ln_on  = 1'b1;
                ln_m1  = 1'b1;
                ln_pol = pol_q;
            end
            ST_RING_ON: begin
                ln_on  = 1'b1;
                ln_m0  = 1'b1;
                ln_pol = pol_q;
            end
            ST_RING_PAUSE: begin
                ln_on  = 1'b1;
                ln_m1  = 1'b1;
            end
            ST_MTR_PRE, ST_MTR_POST: begin
                ln_on   = 1'b1;
                ln_m1   = 1'b1;
                ln_pol  = pol_q;
                mclk_en = 1'b1;
            end
            ST_MTR_ON: begin
                ln_on   = 1'b1;
                ln_m0   = 1'b1;
                ln_m1   = 1'b1;
                ln_pol  = pol_q;
                mclk_en = 1'b1;
            end
            default: begin
                ln_on = 1'b0;
            end
        endcase
    end

    // ---------------- loop status ----------------
    assign hook_feed  = (st == ST_IDLE) || (st == ST_ACT) || in_meter;
    assign hook_sense = hook_feed || in_ring;
    assign hook_clr   = (st == ST_HOLD) || (st == ST_PDN) || (st == ST_THERM);

    sline_hook #(.CNT_W(CNT_W)) u_hook (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .det_q    (det_q),
        .sense    (hook_sense),
        .feed     (hook_feed),
        .clr      (hook_clr),
        .hold_len (cfg_onhook),
        .offhook  (offhook)
    );

endmodule

// File: rtl/sline_ctrl_chk.sv
module sline_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic therm_alarm,
    input logic det_q,
    input logic ln_on,
    input logic ln_m0,
    input logic ln_m1,
    input logic ln_pol,
    input logic mclk_en
);

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!ln_on && !ln_m0 && !ln_m1 && !ln_pol && !mclk_en)); // R1

    AST_OPEN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !ln_on |-> (!ln_m0 && !ln_m1)); // R2

    AST_RING_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_on && ln_m0 && !ln_m1 && det_q && pwr_good && !therm_alarm)
        |=> (ln_on && !ln_m0 && ln_m1 && !ln_pol)); // R7

    AST_METER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_m0 && ln_m1) |-> mclk_en); // R10

    AST_METER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ln_m0 && ln_m1) |-> $past(mclk_en)); // R10

    AST_THERM_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && therm_alarm) |=> !ln_on); // R11

endmodule

bind sline_ctrl sline_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .therm_alarm (therm_alarm),
    .det_q       (det_q),
    .ln_on       (ln_on),
    .ln_m0       (ln_m0),
    .ln_m1       (ln_m1),
    .ln_pol      (ln_pol),
    .mclk_en     (mclk_en)
);

// File: tb/sim_sline_ctrl.sv
`timescale 1ns/1ps
module sim_sline_ctrl;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b1;
    logic         pwr_good = 1'b0;
    logic         therm_alarm = 1'b0;
    logic [1:0]   host_cmd = 2'b10;
    logic         host_rev = 1'b0;
    logic         meter_req = 1'b0;
    logic         det_n = 1'b1;
    logic [W-1:0] cfg_deb    = 16'd3;
    logic [W-1:0] cfg_onhook = 16'd20;
    logic [W-1:0] cfg_half   = 16'd5;
    logic [W-1:0] cfg_burst  = 16'd23;
    logic [W-1:0] cfg_pause  = 16'd12;
    logic [W-1:0] cfg_meter  = 16'd9;
    logic [W-1:0] cfg_guard  = 16'd4;
    logic ln_on, ln_m0, ln_m1, ln_pol, mclk_en, offhook;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    sline_ctrl #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good),
        .therm_alarm(therm_alarm), .host_cmd(host_cmd), .host_rev(host_rev),
        .meter_req(meter_req), .det_n(det_n), .cfg_deb(cfg_deb),
        .cfg_onhook(cfg_onhook), .cfg_half(cfg_half), .cfg_burst(cfg_burst),
        .cfg_pause(cfg_pause), .cfg_meter(cfg_meter), .cfg_guard(cfg_guard),
        .ln_on(ln_on), .ln_m0(ln_m0), .ln_m1(ln_m1), .ln_pol(ln_pol),
        .mclk_en(mclk_en), .offhook(offhook)
    );

    function automatic logic [3:0] lines();
        return {ln_on, ln_m0, ln_m1, ln_pol};
    endfunction

    // expected {on, m0, m1, pol} for a settled command (ring: start of burst)
    function automatic logic [3:0] exp_lines(logic [1:0] cmd, logic rev, logic hot);
        if (hot) return 4'b0000;
        case (cmd)
            2'b00:   return 4'b0000;
            2'b01:   return 4'b1000;
            2'b10:   return {3'b101, rev};
            default: return 4'b1100;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    int seg;
    int cnt;
    int guard;
    logic last_pol;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [1:0] prev_cmd;
        // ---- R1: reset and supply hold ----
        step(3);
        check("R1 reset lines", lines(), 0);
        check("R1 reset mclk", mclk_en, 0);
        rst_n = 1'b1;
        step(8);
        check("R1 hold without supply", {lines(), mclk_en}, 0);
        pwr_good = 1'b1;
        step(4);
        check("R4 active after supply good", lines(), 4'b1010);
        pwr_good = 1'b0;
        step(1);
        check("R1 supply loss", {lines(), mclk_en}, 0);
        pwr_good = 1'b1;
        step(4);

        // ---- R2, R3 ----
        host_cmd = 2'b00; step(3);
        check("R2 power down", lines(), 4'b0000);
        host_cmd = 2'b01; step(3);
        check("R3 idle feed", lines(), 4'b1000);
        host_cmd = 2'b10; host_rev = 1'b1; step(3);
        check("R4 active reversed", lines(), 4'b1011);
        host_rev = 1'b0; step(2);
        check("R4 active normal", lines(), 4'b1010);

        // ---- R5, R6: ring burst and cadence ----
        host_cmd = 2'b11;
        step(1);
        check("R5 burst entry", lines(), 4'b1100);
        cnt = 0; seg = 0; last_pol = 1'b0; guard = 0;
        begin
            int seg_len [0:7];
            int nseg = 0;
            while (ln_m0 && !ln_m1 && guard < 200) begin
                if (ln_pol != last_pol) begin
                    if (nseg < 8) seg_len[nseg] = seg;
                    nseg++;
                    seg = 0;
                    last_pol = ln_pol;
                end
                seg++; cnt++; guard++;
                step(1);
            end
            check("R6 burst length", cnt, 23);
            check("R5 first half period", seg_len[0], 5);
            check("R5 second half period", seg_len[1], 5);
            check("R5 toggles per burst", nseg, 4);
        end
        cnt = 0; guard = 0;
        while (ln_on && !ln_m0 && ln_m1 && !ln_pol && guard < 200) begin
            cnt++; guard++; step(1);
        end
        check("R6 pause length", cnt, 12);
        check("R6 next burst normal start", lines(), 4'b1100);

        // ---- R7: ring trip ----
        step(3);
        host_rev = 1'b1;
        det_n = 1'b0;
        step(12);
        check("R7 trip to active normal", lines(), 4'b1010);
        check("R7 trip sets offhook", offhook, 1);
        step(30);
        check("R7 polarity held normal", lines(), 4'b1010);
        host_cmd = 2'b10;
        step(3);
        check("R4 polarity after ring withdrawn", lines(), 4'b1011);

        // ---- R8: on-hook release timing ----
        det_n = 1'b1;
        step(15);
        check("R8 offhook held before reference", offhook, 1);
        step(30);
        check("R8 offhook released", offhook, 0);

        // ---- R9: debounce ----
        det_n = 1'b0; step(3); det_n = 1'b1;
        step(12);
        check("R9 glitch ignored", offhook, 0);
        det_n = 1'b0; step(10);
        check("R8 offhook set in active", offhook, 1);
        det_n = 1'b1; step(50);
        check("R8 offhook cleared again", offhook, 0);

        // ---- R10: metering pulse ----
        host_rev = 1'b1; step(2);
        meter_req = 1'b1; step(1); meter_req = 1'b0;
        cnt = 0; guard = 0;
        while (mclk_en && !ln_m0 && guard < 200) begin cnt++; guard++; step(1); end
        check("R10 leading guard", cnt, 4);
        cnt = 0; guard = 0; seg = 1;
        while (ln_m0 && ln_m1 && guard < 200) begin
            if (!ln_pol || !mclk_en) seg = 0;
            cnt++; guard++; step(1);
        end
        check("R10 pulse length", cnt, 9);
        check("R10 polarity and clock held", seg, 1);
        cnt = 0; guard = 0;
        while (mclk_en && !ln_m0 && guard < 200) begin cnt++; guard++; step(1); end
        check("R10 trailing guard", cnt, 4);
        check("R10 back to active", {lines(), mclk_en}, 5'b10110);

        // ---- R11: thermal ----
        therm_alarm = 1'b1; step(2);
        check("R11 forced down", lines(), 4'b0000);
        therm_alarm = 1'b0; step(3);
        check("R11 restored active", lines(), 4'b1011);

        // ---- random mix ----
        prev_cmd = 2'b10;
        for (int i = 0; i < 40; i++) begin
            logic [1:0] c;
            logic r;
            logic hot;
            c = 2'($urandom(i + 17) % 4);
            if (c == 2'b11 && prev_cmd == 2'b11) c = 2'b10;
            r = 1'($urandom % 2);
            hot = ($urandom % 5) == 0;
            host_cmd = c; host_rev = r;
            step(3);
            if (hot) begin
                therm_alarm = 1'b1; step(2);
                check("R11 random forced down", lines(), exp_lines(c, r, 1'b1));
                therm_alarm = 1'b0; step(3);
            end
            case (c)
                2'b00: check("R2 random", lines(), exp_lines(c, r, 1'b0));
                2'b01: check("R3 random", lines(), exp_lines(c, r, 1'b0));
                2'b10: check("R4 random", lines(), exp_lines(c, r, 1'b0));
                default: check("R5 random", lines(), exp_lines(c, r, 1'b0));
            endcase
            prev_cmd = c;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule